// File: doc/BRIEF.md
# OFDM Cyclic Prefix Inserter

This block sits after an inverse transform stage. The stage delivers one time-domain OFDM symbol at a time. Each symbol is N complex samples and arrives as one input packet. The inserter stores the whole symbol. It then emits a single longer packet: first a copy of the final G samples of the symbol (the guard), then the entire symbol in its original order. G is picked at run time through a two-bit guard code. The block-floating-point exponent supplied with the symbol goes out on every beat of the packet it belongs to.

Storage is a pair of N-entry banks used in ping-pong fashion, so one symbol can be written while the previous one is read out. The input is a valid/ready sink with a ready latency of one cycle. The output is a valid/ready source that obeys a four-cycle ready latency: a beat may appear only in a cycle whose ready, four cycles earlier, was high. N is fixed at elaboration and must be a power of two of at least 32 (128, 512, 1024 and 2048 are the intended sizes). Reset is synchronous and active low.

Top module: `cp_inserter`

## Requirements
- R1: While reset is held and in the first cycle after it is released, out_valid is low and in_ready is high.
- R2: Each output packet holds N+G beats, and G is N/4, N/8, N/16 or N/32 for guard codes 0, 1, 2 or 3. Beat k carries input sample N-G+k when k<G, and input sample k-G otherwise.
- R3: out_sop is high on beat 0 of each packet only, and out_eop is high on beat N+G-1 only.
- R4: out_exp equals the in_exp value given with the symbol's start beat, on every beat of that symbol's packet.
- R5: The guard code is taken from cp_code on the accepted start beat only. Changes during the rest of the symbol have no effect, and consecutive symbols may use different codes.
- R6: An input beat is accepted only when in_valid is high and in_ready was high in the previous cycle. Beats presented otherwise leave the buffered data untouched.
- R7: While the block waits for the first sample of a symbol, beats with in_sop low are discarded.
- R8: out_valid is high only if out_ready was high four cycles earlier. Beats held back by this rule are delayed, never lost. With out_ready held high, the beats of a packet come out in consecutive cycles.
- R9: in_ready is low whenever accepting one more beat could overwrite a symbol whose packet has not finished. This happens when the bank being filled has one free slot left and the other bank still awaits output. in_ready rises again once that packet ends.
- R10: Packets leave in the same order the symbols arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cp_code | input | 2 | Guard length code (0: N/4, 1: N/8, 2: N/16, 3: N/32) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input ready (latency one) |
| in_sop | input | 1 | First sample of a symbol |
| in_re | input | 16 | Input sample, real part |
| in_im | input | 16 | Input sample, imaginary part |
| in_exp | input | 6 | Block exponent, taken on the start beat |
| out_ready | input | 1 | Output ready (latency four) |
| out_valid | output | 1 | Output beat valid |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_re | output | 16 | Output sample, real part |
| out_im | output | 16 | Output sample, imaginary part |
| out_exp | output | 6 | Block exponent of the current packet |

## Verification
The bench builds the block with N = 32. At that size all four guard codes give a whole number of samples, including the one-sample guard of code 3. A packet is also short enough that both banks can be filled and held within a few dozen cycles. The design can therefore be pushed into the stall where a bank's final slot is withheld, junk beats can be offered there, and back-pressure patterns can run across two whole packets within a short run.

// File: rtl/cpins_pkg.sv
package cpins_pkg;

    localparam int SW = 16;   // sample component width
    localparam int EW = 6;    // block exponent width

    typedef logic [1:0] gcode_t;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } cplx_t;

    // guard length for a code: N/4, N/8, N/16, N/32
    function automatic int unsigned guard_len(input gcode_t c, input int unsigned n);
        return n >> (int'(c) + 2);
    endfunction

endpackage

// File: rtl/cpins_mem.sv
module cpins_mem
    import cpins_pkg::*;
#(
    parameter int N = 128
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 wbank,
    input  logic [$clog2(N)-1:0] waddr,
    input  cplx_t                wdata,
    input  logic                 rbank,
    input  logic [$clog2(N)-1:0] raddr,
    output cplx_t                rdata
);
    cplx_t rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        cplx_t ram [N];
        always_ff @(posedge clk) begin
            if (we && wbank == 1'(b)) ram[waddr] <= wdata;
        end
        assign rd[b] = ram[raddr];
    end

    assign rdata = rd[rbank];
endmodule

// File: rtl/cpins_wr.sv
module cpins_wr
    import cpins_pkg::*;
#(
    parameter int N = 128
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  gcode_t                 cp_code,
    input  logic [EW-1:0]          in_exp,
    input  logic                   rel,
    input  logic                   rel_bank,
    output logic                   in_ready,
    output logic                   we,
    output logic                   wbank,
    output logic [$clog2(N)-1:0]   waddr,
    output logic [1:0]             full,
    output gcode_t [1:0]           bank_code,
    output logic [1:0][EW-1:0]     bank_exp
);
    localparam int AW = $clog2(N);

    logic          rdy_q;
    logic [AW-1:0] idx;
    logic          wb;
    logic [1:0]    full_q, full_nx;
    logic          at_last, take;

    assign at_last  = (idx == AW'(N - 1));
    // ready only when two more beats fit: one may land after ready drops
    assign in_ready = !full_q[wb] && (!at_last || !full_q[!wb]);
    assign take     = in_valid && rdy_q && (idx != '0 || in_sop);

    always_comb begin
        full_nx = full_q;
        if (rel) full_nx[rel_bank] = 1'b0;
        if (take && at_last) full_nx[wb] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q     <= 1'b0;
            idx       <= '0;
            wb        <= 1'b0;
            full_q    <= '0;
            bank_code <= '0;
            bank_exp  <= '0;
        end else begin
            rdy_q  <= in_ready;
            full_q <= full_nx;
            if (take) begin
                if (idx == '0) begin
                    bank_code[wb] <= cp_code;
                    bank_exp[wb]  <= in_exp;
                end
                if (at_last) begin
                    idx <= '0;
                    wb  <= !wb;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    assign we    = take;
    assign wbank = wb;
    assign waddr = idx;
    assign full  = full_q;
endmodule

// File: rtl/cpins_rd.sv
module cpins_rd
    import cpins_pkg::*;
#(
    parameter int N = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           full,
    input  gcode_t [1:0]         bank_code,
    input  logic [1:0][EW-1:0]   bank_exp,
    input  logic                 out_ready,
    input  cplx_t                rdata,
    output logic [$clog2(N)-1:0] raddr,
    output logic                 rbank,
    output logic                 rel,
    output logic                 rel_bank,
    output logic                 out_valid,
    output logic                 out_sop,
    output logic                 out_eop,
    output cplx_t                out_smp,
    output logic [EW-1:0]        out_exp
);
    localparam int AW = $clog2(N);
    localparam int PW = AW + 1;

    logic [2:0]    rp;      // rp[2] holds ready from three cycles back
    logic [PW-1:0] pos, glen;
    logic          rb, go, last;

    assign glen  = PW'(guard_len(bank_code[rb], N));
    assign go    = full[rb] && rp[2];
    assign last  = (pos == PW'(N) + glen - PW'(1));
    assign raddr = (pos < glen) ? AW'(PW'(N) - glen + pos) : AW'(pos - glen);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp        <= '0;
            pos       <= '0;
            rb        <= 1'b0;
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_smp   <= '0;
            out_exp   <= '0;
        end else begin
            rp        <= {rp[1:0], out_ready};
            out_valid <= go;
            if (go) begin
                out_smp <= rdata;
                out_sop <= (pos == '0);
                out_eop <= last;
                out_exp <= bank_exp[rb];
                if (last) begin
                    pos <= '0;
                    rb  <= !rb;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    assign rel      = go && last;
    assign rel_bank = rb;
    assign rbank    = rb;
endmodule

// File: rtl/cp_inserter.sv
module cp_inserter
    import cpins_pkg::*;
#(
    parameter int N = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cp_code,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_sop,
    input  logic [SW-1:0] in_re,
    input  logic [SW-1:0] in_im,
    input  logic [EW-1:0] in_exp,
    input  logic          out_ready,
    output logic          out_valid,
    output logic          out_sop,
    output logic          out_eop,
    output logic [SW-1:0] out_re,
    output logic [SW-1:0] out_im,
    output logic [EW-1:0] out_exp
);
    localparam int AW = $clog2(N);

    logic              we, wbank, rbank, rel, rel_bank;
    logic [AW-1:0]     waddr, raddr;
    logic [1:0]        full;
    gcode_t [1:0]      bank_code;
    logic [1:0][EW-1:0] bank_exp;
    cplx_t             wdata, rdata, out_smp;

    assign wdata.re = in_re;
    assign wdata.im = in_im;

    cpins_wr #(.N(N)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .cp_code(cp_code), .in_exp(in_exp), .rel(rel), .rel_bank(rel_bank),
        .in_ready(in_ready), .we(we), .wbank(wbank), .waddr(waddr),
        .full(full), .bank_code(bank_code), .bank_exp(bank_exp)
    );

    cpins_mem #(.N(N)) u_mem (
        .clk(clk), .we(we), .wbank(wbank), .waddr(waddr), .wdata(wdata),
        .rbank(rbank), .raddr(raddr), .rdata(rdata)
    );

    cpins_rd #(.N(N)) u_rd (
        .clk(clk), .rst_n(rst_n), .full(full), .bank_code(bank_code),
        .bank_exp(bank_exp), .out_ready(out_ready), .rdata(rdata),
        .raddr(raddr), .rbank(rbank), .rel(rel), .rel_bank(rel_bank),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_smp(out_smp), .out_exp(out_exp)
    );

    assign out_re = out_smp.re;
    assign out_im = out_smp.im;
endmodule

// File: rtl/cpins_chk.sv
module cpins_chk
    import cpins_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          out_ready,
    input logic          out_valid,
    input logic          out_sop,
    input logic          out_eop,
    input logic [EW-1:0] out_exp
);
    logic          in_pkt;
    logic [EW-1:0] exp_hold;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt   <= 1'b0;
            exp_hold <= '0;
        end else if (out_valid) begin
            if (out_sop) exp_hold <= out_exp;
            if (out_eop)      in_pkt <= 1'b0;
            else if (out_sop) in_pkt <= 1'b1;
        end
    end

    a_r8_ready_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(out_ready, 4));

    a_r3_sop_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> !in_pkt);

    a_r3_body_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> in_pkt);

    a_r3_marks_apart: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_sop && out_eop));

    a_r4_exp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sop) |-> (out_exp == exp_hold));
endmodule

bind cp_inserter cpins_chk u_chk (
    .clk(clk), .rst_n(rst_n), .out_ready(out_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_exp(out_exp)
);

// File: tb/cp_inserter_test.sv
`timescale 1ns/1ps
module cp_inserter_test;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cp_code = 2'd0;
    logic        in_valid = 1'b0, in_sop = 1'b0, out_ready = 1'b0;
    logic [15:0] in_re = '0, in_im = '0;
    logic [5:0]  in_exp = '0;
    logic        in_ready, out_valid, out_sop, out_eop;
    logic [15:0] out_re, out_im;
    logic [5:0]  out_exp;

    cp_inserter #(.N(N)) uut (
        .clk(clk), .rst_n(rst_n), .cp_code(cp_code), .in_valid(in_valid),
        .in_ready(in_ready), .in_sop(in_sop), .in_re(in_re), .in_im(in_im),
        .in_exp(in_exp), .out_ready(out_ready), .out_valid(out_valid),
        .out_sop(out_sop), .out_eop(out_eop), .out_re(out_re),
        .out_im(out_im), .out_exp(out_exp)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, ocnt = 0, lat_viol = 0;
    logic       rdy_hist = 1'b0;
    logic [3:0] orh = '0;
    logic [15:0] o_re [2048];
    logic [15:0] o_im [2048];
    logic        o_sop [2048];
    logic        o_eop [2048];
    logic [5:0]  o_exp [2048];
    int          o_t   [2048];

    always @(posedge clk) begin
        cyc++;
        rdy_hist <= in_ready;
        orh      <= {orh[2:0], out_ready};
        if (cyc >= 100000) begin
            n_fail++;
            $display("FAIL watchdog: run hung (actual cycle %0d, expected end before 100000)", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (!orh[3]) lat_viol++;
            if (ocnt < 2048) begin
                o_re[ocnt] = out_re;  o_im[ocnt] = out_im;
                o_sop[ocnt] = out_sop; o_eop[ocnt] = out_eop;
                o_exp[ocnt] = out_exp; o_t[ocnt] = cyc;
            end
            ocnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] smp(input int s, input int i);
        return 16'(s * 256 + i);
    endfunction

    // drive junk beats (in_sop low) then cnt symbol samples from index first
    task automatic send_beats(input int s, input int c, input int first,
                              input int cnt, input int junk, input bit chg);
        int i = 0;
        while (i < junk + cnt) begin
            @(negedge clk);
            if (rdy_hist) begin
                in_valid = 1'b1;
                if (i < junk) begin
                    in_sop = 1'b0; in_re = 16'h7777; in_im = 16'h7777; in_exp = 6'd63;
                end else begin
                    int idx = first + i - junk;
                    in_sop  = (idx == 0);
                    in_re   = smp(s, idx);
                    in_im   = ~smp(s, idx);
                    in_exp  = 6'(s);
                    cp_code = (chg && idx >= N/2) ? 2'(c ^ 3) : 2'(c);
                end
                i++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic wait_beats(input int n);
        int t = 0;
        while (ocnt < n && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic check_pkt(input int base, input int s, input int c, input string req);
        int g = N >> (c + 2);
        int len = N + g;
        int bad_d = -1, bad_m = -1, bad_e = -1;
        wait_beats(base + len);
        chk(ocnt >= base + len, req, "packet beats seen", ocnt - base, len);
        for (int k = 0; k < len; k++) begin
            int idx = (k < g) ? N - g + k : k - g;
            if (bad_d < 0 && (o_re[base+k] != smp(s, idx) || o_im[base+k] != ~smp(s, idx))) bad_d = k;
            if (bad_m < 0 && (o_sop[base+k] != (k == 0) || o_eop[base+k] != (k == len-1))) bad_m = k;
            if (bad_e < 0 && o_exp[base+k] != 6'(s)) bad_e = k;
        end
        chk(bad_d < 0, {req, " R2"}, "first data mismatch at beat", bad_d, -1);
        chk(bad_m < 0, {req, " R3"}, "first marker mismatch at beat", bad_m, -1);
        chk(bad_e < 0, {req, " R4"}, "first exponent mismatch at beat", bad_e, -1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    endtask

    task automatic t_codes();
        out_ready = 1'b1;
        repeat (6) @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            int base = ocnt;
            int gap = 0;
            send_beats(c + 1, c, 0, N, 0, 1'b0);
            check_pkt(base, c + 1, c, "R2");
            for (int k = 1; k < N + (N >> (c + 2)); k++)
                if (o_t[base+k] != o_t[base+k-1] + 1) gap++;
            chk(gap == 0, "R8", "gaps in packet with ready high", gap, 0);
        end
    endtask

    task automatic t_b2b();
        int base = ocnt;
        send_beats(10, 1, 0, N, 0, 1'b0);
        send_beats(11, 3, 0, N, 0, 1'b0);
        check_pkt(base, 10, 1, "R10 R5");
        check_pkt(base + N + N/8, 11, 3, "R10 R5");
    endtask

    task automatic t_mid_change();
        int base = ocnt;
        send_beats(12, 2, 0, N, 0, 1'b1);
        check_pkt(base, 12, 2, "R5");
    endtask

    task automatic t_junk();
        int base = ocnt;
        send_beats(13, 0, 0, N, 3, 1'b0);
        check_pkt(base, 13, 0, "R7");
    endtask

    task automatic t_stall();
        int base;
        out_ready = 1'b0;
        repeat (8) @(negedge clk);
        base = ocnt;
        send_beats(20, 1, 0, N, 0, 1'b0);
        send_beats(21, 2, 0, N - 1, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R9", "in_ready with one slot left", in_ready, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_re = 16'h5555; in_im = 16'h5555;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R9", "in_ready still low", in_ready, 0);
        chk(ocnt == base, "R8", "beats while ready low", ocnt - base, 0);
        out_ready = 1'b1;
        send_beats(21, 2, N - 1, 1, 0, 1'b0);
        check_pkt(base, 20, 1, "R6");
        check_pkt(base + N + N/8, 21, 2, "R6");
        repeat (40) @(negedge clk);
        chk(ocnt == base + 2*N + N/8 + N/16, "R6", "total beats after stall",
            ocnt - base, 2*N + N/8 + N/16);
        chk(in_ready == 1'b1, "R9", "in_ready after drain", in_ready, 1);
    endtask

    task automatic t_backpressure();
        int base = ocnt;
        lat_viol = 0;
        fork
            begin
                send_beats(30, 0, 0, N, 0, 1'b0);
                send_beats(31, 2, 0, N, 0, 1'b0);
            end
            begin
                for (int k = 0; k < 600; k++) begin
                    @(negedge clk);
                    out_ready = ((k % 7) < 3) || (k >= 500);
                end
            end
        join
        check_pkt(base, 30, 0, "R8");
        check_pkt(base + N + N/4, 31, 2, "R8");
        chk(lat_viol == 0, "R8", "beats without ready four cycles back", lat_viol, 0);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_b2b();
        t_mid_change();
        t_junk();
        t_stall();
        t_backpressure();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule